// File: doc/BRIEF.md
# Interrupt Pin Swizzle and Router

This block merges level-sensitive interrupt requests from up to 64 devices onto a small vector of controller inputs. Each device reports a change of its request level together with its own index, its slot number and the pin it raises (A to D). The block rotates the pin by the slot onto one of four shared request lines. For every line it keeps one level bit per device. A line is active while any of its device bits is set.

Each shared line has an 8-bit route register that names a controller input, or switches the line off. Every controller input is driven with the OR of all active lines routed to it. A single strobe loads the usual default routing. A route write can change one line at a time. Every output is registered.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, every route register holds 0x80 (line off), every device bit is clear, and `tgt_level` is all zeros.
- R2: A device on slot S raising pin P (encoding 0=A, 1=B, 2=C, 3=D) lands on shared line (P + S - 1) mod 4. Only the low two slot bits matter, so slots 0 and 4 both rotate by minus one.
- R3: Each line keeps a separate level bit for every device index. The line stays active while any of those bits is set, even after another device drops its request.
- R4: `rt_sel` (0 to 3) picks the line whose route register `rt_data` overwrites. A value with bit 7 clear and bits 6:4 zero routes the line to the target numbered by bits 3:0.
- R5: A route value with bit 7 set switches its line off, so the line drives no target.
- R6: A target's level is the OR of every active line whose route names that target. When two lines share a target, the target stays high while either line is active.
- R7: A pulse on `load_dflt` sets lines 0 to 3 to targets 11, 9, 11 and 9. It takes priority over a route write in the same cycle.
- R8: A device update or route change first shows on `tgt_level` at the clock edge that samples it. With no update, `tgt_level` holds its value.
- R9: A route value with bit 7 clear but bits 6:4 nonzero, or one naming a target at or above `N_TGT`, is out of range and drives no target.
- R10: An update with level 0 clears only the bit of that device on the line computed from its slot and pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_we | input | 1 | Device level update strobe |
| dev_idx | input | 6 | Index of the updating device |
| dev_slot | input | 5 | Slot number of the updating device |
| dev_pin | input | 2 | Interrupt pin, 0=A to 3=D |
| dev_level | input | 1 | New request level of that device pin |
| rt_we | input | 1 | Route register write strobe |
| rt_sel | input | 2 | Shared line whose route register is written |
| rt_data | input | 8 | New route register value |
| load_dflt | input | 1 | Load the default routing into all four lines |
| tgt_level | output | 16 | Level of each controller input |

## Verification
The checker watches four things on every cycle:
- `tgt_level` stays stable across cycles with no update.
- The output is zero whenever no shared line will be active.
- No more targets are high than there are enabled routes.
- A default load always leaves the 11/9/11/9 routing in place.

Only the bench's scenarios can show the rest: the slot rotation arithmetic (including wrap-around), sharing of a line by several devices, merging of two lines onto one target, and rejection of disabled or out-of-range route values. The behavioural model in the bench checks each of these against the output on every clock.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
    localparam int NLINES  = 4;
    localparam int ROUTE_W = 8;
    localparam int LINE_W  = $clog2(NLINES);

    typedef logic [ROUTE_W-1:0] route_t;
    typedef logic [NLINES-1:0][ROUTE_W-1:0] route_vec_t;

    // Route value of 0x80 switches a line off
    localparam route_t ROUTE_OFF = 8'h80;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle
    import irq_rt_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        pin,
    output logic [LINE_W-1:0] line
);
    // Rotate pin by slot, minus one, modulo the line count
    always_comb begin
        line = LINE_W'(pin) + LINE_W'(slot) - LINE_W'(1);
    end
endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_rt_pkg::*;
#(
    parameter int N_DEV = 64,
    localparam int IDX_W = $clog2(N_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LINE_W-1:0] line,
    input  logic              level,
    output logic [NLINES-1:0] line_nxt
);
    typedef struct packed {
        logic [NLINES-1:0][N_DEV-1:0] map;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.map[line][idx] = level;
        end
        for (int l = 0; l < NLINES; l++) begin
            line_nxt[l] = |st_d.map[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_route_file.sv
module irq_route_file
    import irq_rt_pkg::*;
#(
    parameter route_vec_t RST_ROUTE  = {NLINES{ROUTE_OFF}},
    parameter route_vec_t DFLT_ROUTE = {8'd9, 8'd11, 8'd9, 8'd11}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LINE_W-1:0] sel,
    input  route_t            data,
    input  logic              load_dflt,
    output route_vec_t        route_nxt,
    output route_vec_t        route_q
);
    typedef struct packed {
        route_vec_t route;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_dflt) begin
            st_d.route = DFLT_ROUTE;
        end else if (we) begin
            st_d.route[sel] = data;
        end
        route_nxt = st_d.route;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.route <= RST_ROUTE;
        else        st_q       <= st_d;
    end

    assign route_q = st_q.route;
endmodule

// File: rtl/irq_target_or.sv
module irq_target_or
    import irq_rt_pkg::*;
#(
    parameter int N_TGT = 16
) (
    input  logic [NLINES-1:0] line_act,
    input  route_vec_t        route,
    output logic [N_TGT-1:0]  tgt
);
    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        logic [NLINES-1:0] hit;
        for (genvar l = 0; l < NLINES; l++) begin : g_line
            assign hit[l] = !route[l][7] && (route[l][6:4] == 3'd0)
                            && (32'(route[l][3:0]) == t);
        end
        assign tgt[t] = |(hit & line_act);
    end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_rt_pkg::*;
#(
    parameter int N_DEV  = 64,
    parameter int N_TGT  = 16,
    parameter int SLOT_W = 5,
    localparam int IDX_W = $clog2(N_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_we,
    input  logic [IDX_W-1:0]  dev_idx,
    input  logic [SLOT_W-1:0] dev_slot,
    input  logic [1:0]        dev_pin,
    input  logic              dev_level,
    input  logic              rt_we,
    input  logic [LINE_W-1:0] rt_sel,
    input  logic [7:0]        rt_data,
    input  logic              load_dflt,
    output logic [N_TGT-1:0]  tgt_level
);
    typedef struct packed {
        logic [N_TGT-1:0] tgt;
    } top_t;

    logic [LINE_W-1:0] dev_line;
    logic [NLINES-1:0] line_nxt;
    route_vec_t        route_nxt, route_q;
    logic [N_TGT-1:0]  tgt_nxt;
    top_t              st_d, st_q;

    irq_swizzle #(.SLOT_W(SLOT_W)) u_swz (
        .slot(dev_slot), .pin(dev_pin), .line(dev_line)
    );

    irq_line_bank #(.N_DEV(N_DEV)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(dev_we), .idx(dev_idx),
        .line(dev_line), .level(dev_level), .line_nxt(line_nxt)
    );

    irq_route_file u_rf (
        .clk(clk), .rst_n(rst_n), .we(rt_we), .sel(rt_sel), .data(rt_data),
        .load_dflt(load_dflt), .route_nxt(route_nxt), .route_q(route_q)
    );

    irq_target_or #(.N_TGT(N_TGT)) u_or (
        .line_act(line_nxt), .route(route_nxt), .tgt(tgt_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.tgt = tgt_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_level = st_q.tgt;
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk
    import irq_rt_pkg::*;
#(
    parameter int N_TGT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_we,
    input logic              rt_we,
    input logic              load_dflt,
    input logic [N_TGT-1:0]  tgt_level,
    input route_vec_t        route_q,
    input logic [NLINES-1:0] line_nxt
);
    logic [2:0] n_en;
    always_comb begin
        n_en = '0;
        for (int l = 0; l < NLINES; l++) begin
            if (!route_q[l][7]) n_en = n_en + 3'd1;
        end
    end

    // R8: no update means the output holds
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_we && !rt_we && !load_dflt) |=> $stable(tgt_level));

    // R3: no active line next means no target high
    a_r3_quiet_without_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (line_nxt == '0) |=> (tgt_level == '0));

    // R5: targets high never outnumber enabled routes
    a_r5_off_routes_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tgt_level) <= 32'(n_en)));

    // R7: default load leaves 11/9/11/9
    a_r7_default_routing: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt |=> (route_q == {8'd9, 8'd11, 8'd9, 8'd11}));
endmodule

bind irq_pin_router irq_pin_router_chk #(.N_TGT(N_TGT)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_we(dev_we), .rt_we(rt_we),
    .load_dflt(load_dflt), .tgt_level(tgt_level), .route_q(route_q),
    .line_nxt(line_nxt)
);

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       dev_we = 0;
    logic [5:0] dev_idx = 0;
    logic [4:0] dev_slot = 0;
    logic [1:0] dev_pin = 0;
    logic       dev_level = 0;
    logic       rt_we = 0;
    logic [1:0] rt_sel = 0;
    logic [7:0] rt_data = 0;
    logic       load_dflt = 0;
    logic [15:0] tgt_level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model
    int mbits [4][64];
    int mrt [4];

    irq_pin_router dut (
        .clk(clk), .rst_n(rst_n), .dev_we(dev_we), .dev_idx(dev_idx),
        .dev_slot(dev_slot), .dev_pin(dev_pin), .dev_level(dev_level),
        .rt_we(rt_we), .rt_sel(rt_sel), .rt_data(rt_data),
        .load_dflt(load_dflt), .tgt_level(tgt_level)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] model_out();
        logic [15:0] o = '0;
        for (int l = 0; l < 4; l++) begin
            int any = 0;
            for (int d = 0; d < 64; d++) any = any | mbits[l][d];
            if (any != 0 && mrt[l] < 128 && (mrt[l] / 16) == 0)
                o[mrt[l] % 16] = 1'b1;
        end
        return o;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 4; l++) begin
                mrt[l] = 128;
                for (int d = 0; d < 64; d++) mbits[l][d] = 0;
            end
        end else begin
            if (load_dflt) begin
                mrt[0] = 11; mrt[1] = 9; mrt[2] = 11; mrt[3] = 9;
            end else if (rt_we) begin
                mrt[rt_sel] = rt_data;
            end
            if (dev_we)
                mbits[(int'(dev_pin) + int'(dev_slot) + 3) % 4][dev_idx] = dev_level;
        end
    end

    task automatic check(string req, logic [15:0] exp);
        total++;
        if (tgt_level !== exp) begin
            bad++;
            $display("FAIL %s: tgt_level=%h expected=%h", req, tgt_level, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) check("R8 model", model_out());
    end

    task automatic dev(int idx, int slot, int pin, int lvl);
        @(negedge clk);
        dev_we = 1; dev_idx = 6'(idx); dev_slot = 5'(slot);
        dev_pin = 2'(pin); dev_level = lvl[0];
        @(negedge clk);
        dev_we = 0;
    endtask

    task automatic route(int sel, int val);
        @(negedge clk);
        rt_we = 1; rt_sel = 2'(sel); rt_data = 8'(val);
        @(negedge clk);
        rt_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset zero", 16'h0000);
        dev(3, 1, 0, 1);                       // line 0, route off
        check("R1 line0 route off at reset", 16'h0000);
        @(negedge clk); load_dflt = 1; @(negedge clk); load_dflt = 0;
        check("R7 default line0 to 11", 16'h0800);
        dev(5, 2, 0, 1);                       // line 1 -> 9
        check("R2 slot2 pinA to line1", 16'h0A00);
        dev(7, 0, 1, 1);                       // slot0 pinB -> line 0
        check("R2 slot0 pinB to line0", 16'h0A00);
        dev(3, 1, 0, 0);
        check("R3 line0 held by other device", 16'h0A00);
        dev(7, 0, 1, 0);
        check("R10 clear only own bit", 16'h0200);
        route(1, 8'h85);
        check("R5 bit7 disables line", 16'h0000);
        route(1, 8'h24);
        check("R9 bits 6:4 set ignored", 16'h0000);
        // R8: change is not visible before the sampling edge
        @(negedge clk);
        rt_we = 1; rt_sel = 2'd1; rt_data = 8'h04;
        #2 check("R8 before edge unchanged", 16'h0000);
        @(negedge clk);
        rt_we = 0;
        check("R4 route line1 to target 4", 16'h0010);
        dev(9, 3, 2, 1);                       // (2+3-1)%4 = 0 -> 11
        check("R2 slot3 pinC wraps to line0", 16'h0810);
        route(0, 8'h04);
        check("R6 two lines on one target", 16'h0010);
        dev(5, 2, 0, 0);
        check("R6 target held by remaining line", 16'h0010);
        dev(11, 4, 1, 1);                      // slot4 pinB -> line0
        check("R2 slot4 same as slot0", 16'h0010);
        @(negedge clk);
        load_dflt = 1; rt_we = 1; rt_sel = 2'd0; rt_data = 8'h03;
        @(negedge clk);
        load_dflt = 0; rt_we = 0;
        check("R7 default beats route write", 16'h0800);
        repeat (3) @(negedge clk);
        check("R8 holds while idle", 16'h0800);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule